// File: doc/BRIEF.md
# Configuration Cycle Translator

This block turns one configuration request from a host into a single configuration access on a 32-bit memory-style bus. A request names a bus number, a device, a function, a register offset, a size of 1, 2 or 4 bytes, a direction, and write data. Bus number zero produces a Type 0 cycle. Its device select is a one-hot bit, and the bit is split between an upper-address window register and the cycle address itself. Any other bus number produces a Type 1 cycle, with bus, device and function packed into the address. A parameterised aperture base is ORed into every address that leaves the block.

Reads return the addressed lanes shifted down to bit 0. Writes of 1 or 2 bytes are read-modify-write: the block reads the aligned word, replaces the addressed lane and writes the word back. A fault reported by the bus side ends the access with all-ones read data and blocks any later write. Only one request is in flight at a time. `busy` holds off new requests until the one-cycle `done` pulse.

Top module: `cfg_xlate`

## Requirements
- R1: A size other than 1, 2 or 4 completes with no bus cycle. `done` rises on the cycle after acceptance, with `rsp_err` = 1 and `rsp_rdata` = 0.
- R2: For bus number 0 with device below 16, the device select is bit (device+16) of a 32-bit one-hot word. Select bits inside the window mask (bits 31:26) go to `cfg_window` together with Type 0 code 2. The remaining select bits, plus function at bits 10:8, plus offset with bits 1:0 cleared, form `bus_addr`, ORed with the base 0x0C000000.
- R3: For bus number 0, a device number of 16 or more completes with `rsp_err` = 2 and no bus cycle.
- R4: For a non-zero bus number, `cfg_window` becomes Type 1 code 3. `bus_addr` is base | bus<<16 | device<<11 | function<<8 | (offset & ~3).
- R5: When `single_slot` is high, any device number above 1 completes with `rsp_err` = 2 and no bus cycle, on either cycle type. Device 0 or 1 proceeds normally.
- R6: Read data is the bus word shifted right by 8 × (offset mod 4) and truncated to the requested size, with `rsp_err` = 0.
- R7: A 1- or 2-byte write does one bus read, then one bus write of the same word. In the written word, the 0xFF or 0xFFFF lane at 8 × (offset mod 4) is replaced by the low bytes of the write data; all other bits keep their read value.
- R8: A 4-byte write does no bus read and exactly one bus write of the unchanged write data.
- R9: A bus fault ends the access with `rsp_err` = 3. A faulting read returns `rsp_rdata` = 0xFFFFFFFF, and a faulting read within a sub-word write issues no bus write.
- R10: `busy` is high from the cycle after acceptance until `done`. Requests are ignored while `busy` is high. `done` lasts exactly one cycle and is followed by idle.
- R11: `cfg_window` resets to the Type 0 code 2 and keeps its value when a request is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_slot | input | 1 | Restrict accesses to devices 0 and 1 |
| req_valid | input | 1 | Request present; taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | 0 ok, 1 bad size, 2 no device, 3 bus fault |
| rsp_rdata | output | 32 | Aligned read data |
| bus_rd | output | 1 | Bus read strobe, held until ack |
| bus_wr | output | 1 | Bus write strobe, held until ack |
| bus_addr | output | 32 | Bus word address |
| bus_wdata | output | 32 | Bus write word |
| bus_rdata | input | 32 | Bus read word |
| bus_ack | input | 1 | Bus access complete |
| bus_fault | input | 1 | Bus access faulted, valid with ack |
| cfg_window | output | 32 | Upper-address window register |

## Verification
Errors in the decode stage show up at the ports as soon as the bus strobe rises: `bus_addr` or `cfg_window` carries the wrong select bit, function field or cycle code. Errors in the sequencer show up as an extra or missing bus strobe. They can also show up as a `done` pulse landing one cycle early or late, or a merged word with a stray lane. Every bus read and write is counted and compared with the counts expected for the request, and the backing word is compared after each write. A read fault that still lets a write through therefore shows up within the same request.

// File: rtl/cfg_xlate_pkg.sv
`timescale 1ns/1ps
package cfg_xlate_pkg;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIZE  = 2'd1,
        ERR_NODEV = 2'd2,
        ERR_FAULT = 2'd3
    } cfg_err_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FIN
    } cfg_state_e;

    // what the sequencer keeps of an accepted request
    typedef struct packed {
        logic [1:0] lane;
        logic [2:0] size;
        logic       write;
    } cfg_ctx_t;

    function automatic logic size_legal(logic [2:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

    function automatic logic [31:0] lane_keep(logic [2:0] s);
        case (s)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_gen.sv
`timescale 1ns/1ps
module cfg_addr_gen
    import cfg_xlate_pkg::*;
#(
    parameter int          SLOTS    = 16,
    parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
    parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
    parameter logic [31:0] CODE_T0  = 32'h0000_0002,
    parameter logic [31:0] CODE_T1  = 32'h0000_0003
) (
    input  logic       single_slot,
    input  logic [7:0] bus,
    input  logic [4:0] dev,
    input  logic [2:0] func,
    input  logic [5:0] reg_word,
    input  logic [2:0] size,
    output logic [31:0] addr,
    output logic [31:0] win,
    output cfg_err_e    err
);
    localparam int SEL_LSB = 32 - SLOTS;

    logic        type0;
    logic [31:0] sel_bit;
    logic [31:0] low_fields;

    always_comb begin
        type0      = (bus == 8'd0);
        sel_bit    = (32'(dev) < SLOTS) ? (32'd1 << (32'(dev) + SEL_LSB)) : 32'd0;
        low_fields = {21'd0, func, 8'd0} | {24'd0, reg_word, 2'b00};

        if (!size_legal(size))
            err = ERR_SIZE;
        else if (single_slot && (dev > 5'd1))
            err = ERR_NODEV;
        else if (type0 && (32'(dev) >= SLOTS))
            err = ERR_NODEV;
        else
            err = ERR_NONE;

        if (type0) begin
            win  = CODE_T0 | (sel_bit & WIN_MASK);
            addr = CFG_BASE | (sel_bit & ~WIN_MASK) | low_fields;
        end else begin
            win  = CODE_T1;
            addr = CFG_BASE | {8'd0, bus, 16'd0} | {16'd0, dev, 11'd0} | low_fields;
        end
    end
endmodule

// File: rtl/cfg_lane.sv
`timescale 1ns/1ps
module cfg_lane
    import cfg_xlate_pkg::*;
(
    input  logic [31:0] word,
    input  logic [31:0] wdata,
    input  logic [1:0]  byte_off,
    input  logic [2:0]  size,
    output logic [31:0] rd_aligned,
    output logic [31:0] merged
);
    logic [4:0]  shift;
    logic [31:0] keep;

    always_comb begin
        shift      = {byte_off, 3'b000};
        keep       = lane_keep(size);
        rd_aligned = (word >> shift) & keep;
        if (size == 3'd4)
            merged = wdata;
        else
            merged = (word & ~(keep << shift)) | ((wdata & keep) << shift);
    end
endmodule

// File: rtl/cfg_xlate.sv
`timescale 1ns/1ps
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int          SLOTS    = 16,
    parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
    parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
    parameter logic [31:0] CODE_T0  = 32'h0000_0002,
    parameter logic [31:0] CODE_T1  = 32'h0000_0003
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        single_slot,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_func,
    input  logic [7:0]  req_off,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    input  logic        bus_fault,
    output logic [31:0] cfg_window
);
    cfg_state_e  state;
    cfg_ctx_t    ctx_q;
    cfg_err_e    err_q;
    logic [31:0] win_q, addr_q, wdata_q, rdata_q;

    logic [31:0] gen_addr, gen_win;
    cfg_err_e    gen_err;
    logic [31:0] rd_aligned, merged;

    cfg_addr_gen #(
        .SLOTS(SLOTS), .CFG_BASE(CFG_BASE), .WIN_MASK(WIN_MASK),
        .CODE_T0(CODE_T0), .CODE_T1(CODE_T1)
    ) u_addr (
        .single_slot(single_slot),
        .bus(req_bus),
        .dev(req_dev),
        .func(req_func),
        .reg_word(req_off[7:2]),
        .size(req_size),
        .addr(gen_addr),
        .win(gen_win),
        .err(gen_err)
    );

    cfg_lane u_lane (
        .word(bus_rdata),
        .wdata(wdata_q),
        .byte_off(ctx_q.lane),
        .size(ctx_q.size),
        .rd_aligned(rd_aligned),
        .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctx_q   <= '0;
            err_q   <= ERR_NONE;
            win_q   <= CODE_T0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    ctx_q   <= '{lane: req_off[1:0], size: req_size, write: req_write};
                    err_q   <= gen_err;
                    rdata_q <= '0;
                    wdata_q <= req_wdata;
                    if (gen_err != ERR_NONE) begin
                        state <= ST_FIN;
                    end else begin
                        win_q  <= gen_win;
                        addr_q <= gen_addr;
                        state  <= (req_write && req_size == 3'd4) ? ST_WRITE : ST_READ;
                    end
                end
                ST_READ: if (bus_ack) begin
                    if (bus_fault) begin
                        rdata_q <= 32'hFFFF_FFFF;
                        err_q   <= ERR_FAULT;
                        state   <= ST_FIN;
                    end else if (ctx_q.write) begin
                        wdata_q <= merged;
                        state   <= ST_WRITE;
                    end else begin
                        rdata_q <= rd_aligned;
                        state   <= ST_FIN;
                    end
                end
                ST_WRITE: if (bus_ack) begin
                    if (bus_fault)
                        err_q <= ERR_FAULT;
                    state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_FIN);
    assign rsp_err    = err_q;
    assign rsp_rdata  = rdata_q;
    assign bus_rd     = (state == ST_READ);
    assign bus_wr     = (state == ST_WRITE);
    assign bus_addr   = addr_q;
    assign bus_wdata  = wdata_q;
    assign cfg_window = win_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R1
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4)
        |=> (done && rsp_err == 2'd1));

    // R9
    fault_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_ack && bus_fault) |=> (!bus_wr && done && rsp_rdata == 32'hFFFF_FFFF));

    // R10
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R11
    window_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (rsp_err == 2'd1 || rsp_err == 2'd2)) |-> $stable(cfg_window));
endmodule

// File: tb/cfg_xlate_test.sv
`timescale 1ns/1ps
module cfg_xlate_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        single_slot = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0, req_off = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0, req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, bus_rd, bus_wr, bus_ack, bus_fault;
    logic [1:0]  rsp_err;
    logic [31:0] rsp_rdata, bus_addr, bus_wdata, bus_rdata, cfg_window;

    cfg_xlate uut (
        .clk(clk), .rst(rst), .single_slot(single_slot), .req_valid(req_valid),
        .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev),
        .req_func(req_func), .req_off(req_off), .req_size(req_size),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_fault(bus_fault), .cfg_window(cfg_window)
    );

    // bus-side model: one word, immediate ack, fault at a fixed address
    localparam logic [31:0] FAULT_AT = 32'h0C00_0040;
    logic [31:0] mem_word = '0, last_addr = '0, load_val = '0;
    logic        load_mem = 1'b0, clr_cnt = 1'b0;
    int          n_rd = 0, n_wr = 0;

    assign bus_ack   = bus_rd | bus_wr;
    assign bus_fault = (bus_rd | bus_wr) && (bus_addr == FAULT_AT);
    assign bus_rdata = mem_word;

    always @(posedge clk) begin
        if (load_mem) mem_word <= load_val;
        if (clr_cnt) begin
            n_rd <= 0;
            n_wr <= 0;
        end else begin
            if (bus_rd && bus_ack) begin n_rd <= n_rd + 1; last_addr <= bus_addr; end
            if (bus_wr && bus_ack) begin
                n_wr <= n_wr + 1;
                last_addr <= bus_addr;
                if (!bus_fault) mem_word <= bus_wdata;
            end
        end
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    typedef struct packed {
        logic        single;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  func;
        logic [7:0]  off;
        logic [2:0]  size;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] mem0;
        logic [1:0]  e_err;
        logic [31:0] e_rdata;
        logic        chk_rd;
        logic [31:0] e_addr;
        logic [31:0] e_win;
        logic [1:0]  e_nrd;
        logic [1:0]  e_nwr;
        logic [31:0] e_mem;
    } vec_t;

    localparam logic [31:0] M = 32'h1122_3344;
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0, 5'd2,  3'd1, 8'h06, 3'd2, 1'b0, 32'h0, M, 2'd0, 32'h0000_1122, 1'b1, 32'h0C04_0104, 32'h0000_0002, 2'd1, 2'd0, M},
        '{1'b0, 8'd0, 5'd12, 3'd0, 8'h13, 3'd1, 1'b0, 32'h0, M, 2'd0, 32'h0000_0011, 1'b1, 32'h0C00_0010, 32'h1000_0002, 2'd1, 2'd0, M},
        '{1'b0, 8'd5, 5'd3,  3'd2, 8'h08, 3'd4, 1'b0, 32'h0, M, 2'd0, M,             1'b1, 32'h0C05_1A08, 32'h0000_0003, 2'd1, 2'd0, M},
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h05, 3'd1, 1'b1, 32'h0000_00AB, M, 2'd0, 32'h0, 1'b0, 32'h0C01_0004, 32'h0000_0002, 2'd1, 2'd1, 32'h1122_AB44},
        '{1'b0, 8'd1, 5'd31, 3'd7, 8'hFE, 3'd2, 1'b1, 32'h1234_5678, M, 2'd0, 32'h0, 1'b0, 32'h0C01_FFFC, 32'h0000_0003, 2'd1, 2'd1, 32'h5678_3344},
        '{1'b0, 8'd0, 5'd15, 3'd3, 8'h20, 3'd4, 1'b1, 32'hDEAD_BEEF, M, 2'd0, 32'h0, 1'b0, 32'h0C00_0320, 32'h8000_0002, 2'd0, 2'd1, 32'hDEAD_BEEF},
        '{1'b0, 8'd0, 5'd1,  3'd0, 8'h00, 3'd3, 1'b0, 32'h0, M, 2'd1, 32'h0, 1'b1, 32'h0, 32'h8000_0002, 2'd0, 2'd0, M},
        '{1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, M, 2'd2, 32'h0, 1'b1, 32'h0, 32'h8000_0002, 2'd0, 2'd0, M},
        '{1'b1, 8'd3, 5'd2,  3'd0, 8'h00, 3'd4, 1'b0, 32'h0, M, 2'd2, 32'h0, 1'b1, 32'h0, 32'h8000_0002, 2'd0, 2'd0, M},
        '{1'b1, 8'd0, 5'd1,  3'd0, 8'h00, 3'd4, 1'b0, 32'h0, M, 2'd0, M,    1'b1, 32'h0C02_0000, 32'h0000_0002, 2'd1, 2'd0, M},
        '{1'b0, 8'd0, 5'd1,  3'd0, 8'h00, 3'd0, 1'b1, 32'h55, M, 2'd1, 32'h0, 1'b0, 32'h0, 32'h0000_0002, 2'd0, 2'd0, M},
        '{1'b0, 8'd0, 5'd10, 3'd0, 8'h40, 3'd4, 1'b0, 32'h0, M, 2'd3, 32'hFFFF_FFFF, 1'b1, 32'h0C00_0040, 32'h0400_0002, 2'd1, 2'd0, M},
        '{1'b0, 8'd0, 5'd10, 3'd0, 8'h41, 3'd1, 1'b1, 32'h99, M, 2'd3, 32'h0, 1'b0, 32'h0C00_0040, 32'h0400_0002, 2'd1, 2'd0, M},
        '{1'b0, 8'd0, 5'd10, 3'd0, 8'h40, 3'd4, 1'b1, 32'h77, M, 2'd3, 32'h0, 1'b0, 32'h0C00_0040, 32'h0400_0002, 2'd0, 2'd1, M}
    };
    localparam string TAGS [NV] = '{"R6", "R2", "R4", "R7", "R7", "R8", "R1",
                                    "R3", "R5", "R5", "R1", "R9", "R9", "R9"};

    task automatic preset(logic [31:0] v);
        @(negedge clk);
        load_val = v; load_mem = 1'b1; clr_cnt = 1'b1;
        @(negedge clk);
        load_mem = 1'b0; clr_cnt = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_vec(vec_t v, string tag);
        preset(v.mem0);
        single_slot = v.single; req_bus = v.bus; req_dev = v.dev; req_func = v.func;
        req_off = v.off; req_size = v.size; req_write = v.wr; req_wdata = v.wdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk(tag, "done", 32'(done), 32'd1);
        chk(tag, "err", 32'(rsp_err), 32'(v.e_err));
        if (v.chk_rd) chk(tag, "rdata", rsp_rdata, v.e_rdata);
        if (v.e_nrd != 2'd0 || v.e_nwr != 2'd0) chk(tag, "addr", last_addr, v.e_addr);
        chk("R11", "window", cfg_window, v.e_win);
        chk(tag, "reads", 32'(n_rd), 32'(v.e_nrd));
        chk(tag, "writes", 32'(n_wr), 32'(v.e_nwr));
        chk(tag, "word", mem_word, v.e_mem);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, R10 idle outputs
        chk("R11", "reset window", cfg_window, 32'h0000_0002);
        chk("R10", "reset busy", 32'(busy), 32'd0);
        chk("R10", "reset done", 32'(done), 32'd0);
        chk("R10", "reset strobes", 32'({bus_rd, bus_wr}), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], TAGS[i]);

        // R10: request held high through a whole access is taken once
        preset(M);
        single_slot = 1'b0; req_bus = 8'd0; req_dev = 5'd1; req_func = 3'd0;
        req_off = 8'h00; req_size = 3'd4; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        chk("R10", "busy after accept", 32'(busy), 32'd1);
        wait_done();
        req_valid = 1'b0;
        chk("R10", "single read while held", 32'(n_rd), 32'd1);
        @(negedge clk);
        chk("R10", "done one cycle", 32'(done), 32'd0);
        chk("R10", "idle after done", 32'(busy), 32'd0);
        chk("R10", "no extra access", 32'(n_rd), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule